// File: doc/BRIEF.md
# Boot Remap and Memory Idle Controller

This block holds the memory controller's single control word and turns its bits into live behaviour. A remap flag decides whether the lowest 256 MB of the address space is served by the boot ROM or by the normally mapped memories. The flag starts cleared, so the first fetches after reset land in the boot ROM. Boot code then sets the flag, and software may clear it again later to bring the boot ROM back into the low region.

When the flag is set, the top region nibble of each request is compared against the SDRAM and flash region numbers. A request that no memory claims raises a one-cycle error. The same word also picks the source of the SDRAM clock pin: the real SDRAM clock or a software-driven bit. It also selects whether the controller drops into an automatic idle state after a run of request-free cycles. Two enable bits are passed out for the SDRAM controller and the debug port.

Requests arrive as a valid strobe with an address. They are always accepted in the cycle they are presented, so the request side has no ready signal and no back-pressure. The register port is a plain write strobe with a shared address, and read data is returned combinationally.

Top module: `memctl_remap_ctrl`

## Requirements
- R1: After reset every control bit is 0. The control word reads as 0, both enables are low, no chip select is active, idle is low, and the clock pin follows `sdram_clk_in`.
- R2: The control word is at register offset 0x8. Bits [5:0] are read/write, bits [31:6] read 0 and ignore writes. Any other offset reads 0, and writes to it change nothing.
- R3: With bit 0 (remap) at 0, a request whose address bits [31:28] are 0 drives only `cs_n[3]` (boot ROM) low.
- R4: Any request not taken by the boot ROM is routed by its address bits [31:28]. If they equal `sdram_region` and bit 4 is 1, only `cs_n[0]` goes low. Otherwise, if they equal `flash_region`, only `cs_n[1]` goes low. SDRAM has priority over flash.
- R5: A request that no memory claims raises `bus_err` in that cycle with all chip selects high.
- R6: Clearing bit 0 after it was set routes low-region requests back to `cs_n[3]` from the next cycle.
- R7: Without `req_valid`, all chip selects are high and `bus_err` is low. At most one chip select is ever low.
- R8: With bit 2 at 0, `mem_idle` is high once 4 or more consecutive cycles have passed without a request, saturating there. It drops in the same cycle a request is presented, and counting restarts after that request.
- R9: With bit 2 at 1, `mem_idle` stays low.
- R10: With bit 3 at 0, `sdclk_pin` carries `sdram_clk_in`. With bit 3 at 1, it carries bit 1.
- R11: `sdram_en` mirrors bit 4 and `jtag_en` mirrors bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register offset for read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| req_valid | input | 1 | Memory request strobe, always accepted |
| req_addr | input | 32 | Memory request address |
| sdram_region | input | 4 | Region number (address bits [31:28]) of SDRAM |
| flash_region | input | 4 | Region number of flash |
| cs_n | output | 4 | Active-low chip selects: 0 SDRAM, 1 flash, 3 boot ROM |
| bus_err | output | 1 | Unclaimed request in this cycle |
| mem_idle | output | 1 | Controller in automatic idle |
| sdram_clk_in | input | 1 | SDRAM clock to forward |
| sdclk_pin | output | 1 | SDRAM clock pin |
| sdram_en | output | 1 | SDRAM controller enable |
| jtag_en | output | 1 | Debug port enable |

## Verification
The bench builds the block with its default parameters: 4 region bits, 4 chip selects, and an idle threshold of 4 cycles. With these values a random region nibble hits the boot, SDRAM, flash and unclaimed cases often, and the idle counter reaches and holds saturation within a few quiet cycles. The bench also moves the SDRAM and flash region numbers, including onto region 0. This exercises the SDRAM-over-flash priority and the case where a remapped low region lands in SDRAM or flash.

// File: rtl/memctl_remap_pkg.sv
package memctl_remap_pkg;
  localparam int CTL_W = 6;

  // Field order is the software-visible bit order, bit 5 first.
  typedef struct packed {
    logic jtag_en;    // bit 5
    logic sdram_en;   // bit 4
    logic pin_sel;    // bit 3: 1 = pin from soft bit
    logic stay_awake; // bit 2: 1 = never auto-idle
    logic pin_bit;    // bit 1
    logic remap;      // bit 0
  } ctl_t;
endpackage

// File: rtl/memctl_cfg_reg.sv
module memctl_cfg_reg
  import memctl_remap_pkg::*;
#(
  parameter int CFG_AW      = 4,
  parameter int CFG_DW      = 32,
  parameter int CTRL_OFFSET = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  output ctl_t              ctl_o
);
  localparam int PAD_W = CFG_DW - CTL_W;
  localparam logic [CFG_AW-1:0] SEL = CFG_AW'(CTRL_OFFSET);

  ctl_t ctl_q;
  logic hit;
  logic unused_wdata_hi;

  assign hit             = (cfg_addr == SEL);
  assign unused_wdata_hi = ^cfg_wdata[CFG_DW-1:CTL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctl_q <= '0;
    else if (cfg_we && hit)
      ctl_q <= ctl_t'(cfg_wdata[CTL_W-1:0]);
  end

  assign cfg_rdata = hit ? {{PAD_W{1'b0}}, ctl_q} : '0;
  assign ctl_o     = ctl_q;
endmodule

// File: rtl/memctl_addr_dec.sv
module memctl_addr_dec #(
  parameter int REGION_BITS = 4,
  parameter int NUM_CS      = 4,
  parameter int BOOT_CS     = 3,
  parameter int SDRAM_CS    = 0,
  parameter int FLASH_CS    = 1
) (
  input  logic                   req_valid,
  input  logic [REGION_BITS-1:0] req_region,
  input  logic                   remap,
  input  logic                   sdram_on,
  input  logic [REGION_BITS-1:0] sdram_region,
  input  logic [REGION_BITS-1:0] flash_region,
  output logic [NUM_CS-1:0]      cs_n,
  output logic                   err
);
  logic boot_hit, sd_hit, fl_hit;

  // Priority: boot ROM (low region, not remapped), then SDRAM, then flash.
  assign boot_hit = req_valid && (req_region == '0) && !remap;
  assign sd_hit   = req_valid && !boot_hit && sdram_on && (req_region == sdram_region);
  assign fl_hit   = req_valid && !boot_hit && !sd_hit && (req_region == flash_region);
  assign err      = req_valid && !boot_hit && !sd_hit && !fl_hit;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    if (g == BOOT_CS) begin : g_boot
      assign cs_n[g] = !boot_hit;
    end else if (g == SDRAM_CS) begin : g_sdram
      assign cs_n[g] = !sd_hit;
    end else if (g == FLASH_CS) begin : g_flash
      assign cs_n[g] = !fl_hit;
    end else begin : g_spare
      assign cs_n[g] = 1'b1;
    end
  end
endmodule

// File: rtl/memctl_idle_trk.sv
module memctl_idle_trk #(
  parameter int IDLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic stay_awake,
  output logic idle
);
  localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_CYCLES);

  logic [CNT_W-1:0] quiet_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      quiet_q <= '0;
    else if (req_valid)
      quiet_q <= '0;
    else if (quiet_q != LIMIT)
      quiet_q <= quiet_q + 1'b1;
  end

  // A new request pulls idle low in its own cycle, so it is served at once.
  assign idle = !stay_awake && (quiet_q == LIMIT) && !req_valid;
endmodule

// File: rtl/memctl_remap_ctrl.sv
module memctl_remap_ctrl
  import memctl_remap_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int REGION_BITS = 4,
  parameter int NUM_CS      = 4,
  parameter int BOOT_CS     = 3,
  parameter int SDRAM_CS    = 0,
  parameter int FLASH_CS    = 1,
  parameter int IDLE_CYCLES = 4,
  parameter int CFG_AW      = 4,
  parameter int CFG_DW      = 32,
  parameter int CTRL_OFFSET = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [CFG_AW-1:0]      cfg_addr,
  input  logic [CFG_DW-1:0]      cfg_wdata,
  output logic [CFG_DW-1:0]      cfg_rdata,
  input  logic                   req_valid,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [REGION_BITS-1:0] sdram_region,
  input  logic [REGION_BITS-1:0] flash_region,
  output logic [NUM_CS-1:0]      cs_n,
  output logic                   bus_err,
  output logic                   mem_idle,
  input  logic                   sdram_clk_in,
  output logic                   sdclk_pin,
  output logic                   sdram_en,
  output logic                   jtag_en
);
  localparam int OFFS_W = ADDR_W - REGION_BITS;

  ctl_t ctl_q;
  logic [REGION_BITS-1:0] req_region;
  logic unused_addr_lo;

  assign req_region     = req_addr[ADDR_W-1:OFFS_W];
  assign unused_addr_lo = ^req_addr[OFFS_W-1:0];

  memctl_cfg_reg #(
    .CFG_AW(CFG_AW), .CFG_DW(CFG_DW), .CTRL_OFFSET(CTRL_OFFSET)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ctl_o(ctl_q)
  );

  memctl_addr_dec #(
    .REGION_BITS(REGION_BITS), .NUM_CS(NUM_CS), .BOOT_CS(BOOT_CS),
    .SDRAM_CS(SDRAM_CS), .FLASH_CS(FLASH_CS)
  ) u_dec (
    .req_valid(req_valid), .req_region(req_region), .remap(ctl_q.remap),
    .sdram_on(ctl_q.sdram_en), .sdram_region(sdram_region),
    .flash_region(flash_region), .cs_n(cs_n), .err(bus_err)
  );

  memctl_idle_trk #(
    .IDLE_CYCLES(IDLE_CYCLES)
  ) u_idle (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .stay_awake(ctl_q.stay_awake), .idle(mem_idle)
  );

  assign sdclk_pin = ctl_q.pin_sel ? ctl_q.pin_bit : sdram_clk_in;
  assign sdram_en  = ctl_q.sdram_en;
  assign jtag_en   = ctl_q.jtag_en;
endmodule

// File: rtl/memctl_remap_chk.sv
module memctl_remap_chk #(
  parameter int REGION_BITS = 4,
  parameter int NUM_CS      = 4,
  parameter int BOOT_CS     = 3,
  parameter int IDLE_CYCLES = 4,
  parameter int CFG_AW      = 4,
  parameter int CTRL_OFFSET = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic [REGION_BITS-1:0] req_region,
  input logic [NUM_CS-1:0]      cs_n,
  input logic                   bus_err,
  input logic                   mem_idle,
  input logic                   sdclk_pin,
  input logic                   cfg_we,
  input logic [CFG_AW-1:0]      cfg_addr,
  input logic [5:0]             wdata_lo,
  input logic [5:0]             ctl_bits
);
  int quiet;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          quiet <= 0;
    else if (req_valid)  quiet <= 0;
    else if (quiet < IDLE_CYCLES) quiet <= quiet + 1;
  end

  assert_ctl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == CFG_AW'(CTRL_OFFSET)) |=> ctl_bits == $past(wdata_lo));
  assert_ctl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_addr == CFG_AW'(CTRL_OFFSET)) |=> $stable(ctl_bits));
  assert_boot_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_region == '0 && !ctl_bits[0]) |-> !cs_n[BOOT_CS]);
  assert_err_quiet_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (&cs_n));
  assert_one_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  assert_no_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> ((&cs_n) && !bus_err));
  assert_idle_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !mem_idle);
  assert_idle_reach_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_bits[2] && quiet >= IDLE_CYCLES && !req_valid) |-> mem_idle);
  assert_idle_early_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet < IDLE_CYCLES) |-> !mem_idle);
  assert_awake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_bits[2] |-> !mem_idle);
  assert_pin_soft_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_bits[3] |-> (sdclk_pin == ctl_bits[1]));
endmodule

bind memctl_remap_ctrl memctl_remap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
  .req_region(req_addr[31:28]), .cs_n(cs_n), .bus_err(bus_err),
  .mem_idle(mem_idle), .sdclk_pin(sdclk_pin), .cfg_we(cfg_we),
  .cfg_addr(cfg_addr), .wdata_lo(cfg_wdata[5:0]), .ctl_bits(ctl_q)
);

// File: tb/test_memctl_remap_ctrl.sv
module test_memctl_remap_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [3:0]  sdram_region, flash_region;
  logic [3:0]  cs_n;
  logic        bus_err, mem_idle, sdram_clk_in, sdclk_pin, sdram_en, jtag_en;

  always #5 clk = ~clk;

  memctl_remap_ctrl i_memctl_remap_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .sdram_region(sdram_region),
    .flash_region(flash_region), .cs_n(cs_n), .bus_err(bus_err),
    .mem_idle(mem_idle), .sdram_clk_in(sdram_clk_in), .sdclk_pin(sdclk_pin),
    .sdram_en(sdram_en), .jtag_en(jtag_en)
  );

  int n_cmp = 0, n_bad = 0;
  logic [5:0] m_ctl;
  int m_quiet;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Expected chip selects: bit 0 SDRAM, bit 1 flash, bit 3 boot ROM, active low.
  function automatic logic [3:0] f_cs(input logic [5:0] c, input logic rq,
                                      input logic [3:0] rg, input logic [3:0] sr,
                                      input logic [3:0] fr);
    if (!rq) return 4'b1111;
    if (rg == 4'h0 && !c[0]) return 4'b0111;
    if (c[4] && rg == sr) return 4'b1110;
    if (rg == fr) return 4'b1101;
    return 4'b1111;
  endfunction

  function automatic string f_tag(input logic [5:0] c, input logic rq,
                                  input logic [3:0] rg, input logic [3:0] sr,
                                  input logic [3:0] fr);
    if (!rq) return "R7";
    if (rg == 4'h0 && !c[0]) return "R3";
    if ((c[4] && rg == sr) || rg == fr) return "R4";
    return "R5";
  endfunction

  task automatic step(input logic we, input logic [3:0] a, input logic [31:0] wd,
                      input logic rq, input logic [31:0] ra, input logic sck);
    logic [3:0] ecs;
    @(posedge clk);
    #1;
    cfg_we = we; cfg_addr = a; cfg_wdata = wd;
    req_valid = rq; req_addr = ra; sdram_clk_in = sck;
    #3;
    ecs = f_cs(m_ctl, rq, ra[31:28], sdram_region, flash_region);
    chk(f_tag(m_ctl, rq, ra[31:28], sdram_region, flash_region), cs_n, ecs);
    chk(rq && ecs == 4'b1111 ? "R5" : "R7", bus_err, rq && ecs == 4'b1111);
    chk(m_ctl[2] ? "R9" : "R8", mem_idle, !m_ctl[2] && m_quiet >= 4 && !rq);
    chk("R10", sdclk_pin, m_ctl[3] ? m_ctl[1] : sck);
    chk("R2", cfg_rdata, (a == 4'h8) ? {26'b0, m_ctl} : 32'b0);
    chk("R11", {jtag_en, sdram_en}, m_ctl[5:4]);
    if (we && a == 4'h8) m_ctl = wd[5:0];
    m_quiet = rq ? 0 : (m_quiet < 4 ? m_quiet + 1 : 4);
  endtask

  task automatic wr(input logic [31:0] v);
    step(1'b1, 4'h8, v, 1'b0, 32'h0, 1'b0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; cfg_we = 0; cfg_addr = 4'h8; cfg_wdata = 0;
    req_valid = 0; req_addr = 0; sdram_region = 4'h2; flash_region = 4'h1;
    sdram_clk_in = 1'b1;
    m_ctl = 6'h0; m_quiet = 0;
    repeat (3) @(posedge clk);
    #4;
    // R1: reset state
    chk("R1", cfg_rdata, 32'h0);
    chk("R1", {jtag_en, sdram_en, mem_idle, bus_err}, 4'h0);
    chk("R1", cs_n, 4'hF);
    chk("R1", sdclk_pin, 1'b1);
    sdram_clk_in = 1'b0; #1;
    chk("R1", sdclk_pin, 1'b0);
    @(posedge clk); #1 rst_n = 1'b1;
    m_quiet = 1; // the next edge is a quiet cycle out of reset

    // R2: read/write and ignored bits
    wr(32'hFFFF_FFFF);
    step(0, 4'h8, 0, 0, 0, 0);
    wr(32'hFFFF_FFC0);
    step(1, 4'h4, 32'h3F, 0, 0, 0);
    step(0, 4'h4, 0, 0, 0, 0);
    step(0, 4'h8, 0, 0, 0, 0);
    // R3: boot ROM while not remapped
    step(0, 4'h8, 0, 1, 32'h0123_4567, 0);
    step(0, 4'h8, 0, 1, 32'h2000_0000, 0);
    // R4, R5: remapped, SDRAM on low region, flash overlap priority
    sdram_region = 4'h0; flash_region = 4'h0;
    wr(32'h11);
    step(0, 4'h8, 0, 1, 32'h0000_0100, 0);
    wr(32'h01);
    step(0, 4'h8, 0, 1, 32'h0000_0100, 0);
    flash_region = 4'h5;
    step(0, 4'h8, 0, 1, 32'h0000_0100, 0);
    // R6: clear remap, low region back to boot ROM
    wr(32'h10);
    step(0, 4'h8, 0, 1, 32'h0FFF_FFFC, 0);
    chk("R6", cs_n, 4'b0111);
    // R8: idle after quiet cycles, drops on request
    repeat (6) step(0, 4'h0, 0, 0, 0, 0);
    step(0, 4'h0, 0, 1, 32'h5000_0000, 0);
    repeat (3) step(0, 4'h0, 0, 0, 0, 0);
    chk("R8", mem_idle, 1'b0);
    step(0, 4'h0, 0, 0, 0, 0);
    step(0, 4'h0, 0, 0, 0, 0);
    chk("R8", mem_idle, 1'b1);
    // R9: stay awake
    wr(32'h04);
    repeat (6) step(0, 4'h0, 0, 0, 0, 0);
    chk("R9", mem_idle, 1'b0);
    // R10, R11: pin source and enables
    wr(32'h0A);
    step(0, 4'h8, 0, 0, 0, 0);
    wr(32'h28);
    step(0, 4'h8, 0, 0, 0, 1);
    wr(32'h30);
    step(0, 4'h8, 0, 0, 0, 1);

    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r = $urandom;
      logic [31:0] ra = $urandom;
      logic [3:0] pick = 4'($urandom % 4);
      if (i % 50 == 0) begin
        sdram_region = 4'($urandom);
        flash_region = (r[0]) ? sdram_region : 4'($urandom);
      end
      case (pick)
        4'd0: ra[31:28] = 4'h0;
        4'd1: ra[31:28] = sdram_region;
        4'd2: ra[31:28] = flash_region;
        default: ;
      endcase
      step(r[3:0] == 4'h0, (r[4] ? 4'h8 : 4'($urandom)), $urandom,
           r[7:5] < 3'd3, ra, r[8]);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule